// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers end-of-transfer pulses from a bank of DMA channels (64 by default) and folds them into one shared interrupt line. Each channel owns one sticky pending bit, one enable bit and one reset strobe. Pending bits are set by the channel's done pulse. Software clears a pending bit by writing a one to it in a write-one-to-clear word. The enable bits are plain read/write words. Software normally updates them with a read, an OR of the new channel's bit, and a write back.

Channels 0 to 31 live in the lower word of each register pair and channels 32 to 63 in the upper word. A write to a channel's reset slot sends a one-cycle reset pulse to that channel and drops its pending bit. The register port is a simple single-cycle write / registered read interface addressed by byte offset. The channel datapaths are not part of the block.

Top module: `dmairq_agg`

## Requirements
- R1: After reset every pending bit and every enable bit is zero, `irqOut` is low, `chanRst` is all zero and `busRdata` is zero.
- R2: A high `doneIn[n]` at a clock edge sets pending bit n at that edge. Channel n appears at bit n of the word at offset 0x0C when n < 32, and at bit n−32 of the word at offset 0x10 otherwise.
- R3: A pending bit stays set until it is cleared, and writes to the pending words at 0x0C and 0x10 change nothing.
- R4: Writing to offset 0x14 clears pending bit k for every set data bit k (channels 0–31). Writing to offset 0x18 does the same for channel 32+k. Data bits written as zero leave their pending bits unchanged.
- R5: When a done pulse and a clear for the same channel meet in one cycle, the pending bit ends up set.
- R6: The enable words at 0x1C (channels 0–31) and 0x20 (channels 32–63) are read/write. A pending bit only reaches the interrupt while its enable bit is 1.
- R7: `irqOut` is registered. After edge k+1 it equals the OR over all channels of (pending AND enable) as held after edge k.
- R8: The clear words, the reset slots and every unmapped offset read as zero.
- R9: A write with data bit 0 set to offset 0x40 + 4·n (n below the channel count) drives `chanRst[n]` high for exactly the cycle after the write edge, with no other bit set. A write with data bit 0 clear produces no pulse.
- R10: A reset write to channel n clears pending bit n, unless `doneIn[n]` is high in the same cycle, in which case the bit stays set.
- R11: `busRdata` is loaded at the edge where `busRead` is high with the register value held before that edge, and it holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | 12 | Byte offset of the register access |
| busWrite | input | 1 | Write request, taken at the clock edge |
| busWdata | input | 32 | Write data |
| busRead | input | 1 | Read request, taken at the clock edge |
| busRdata | output | 32 | Registered read data |
| doneIn | input | 64 | Per-channel transfer-done pulses |
| chanRst | output | 64 | Per-channel one-cycle reset pulses |
| irqOut | output | 1 | Shared registered interrupt |

## Verification
A done pulse, a clear, an enable write or a reset write changes the pending and enable state at the same edge that samples it. The reset pulse and read data appear after that edge. The interrupt appears one edge later, because it is computed from the already updated state. The bench drives inputs on the falling edge, updates a behavioural model on the rising edge and compares `irqOut`, `chanRst` and `busRdata` against it on every falling edge. Directed checks sample these outputs at the same points. To confirm the extra cycle of interrupt latency, the directed checks sample `irqOut` both directly after an enabling write and one cycle later.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

  localparam int MAX_CH   = 64;
  localparam int CH_IDX_W = $clog2(MAX_CH);
  localparam int WORD_W   = 32;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_STAT_LO,
    RD_STAT_HI,
    RD_MASK_LO,
    RD_MASK_HI
  } rdSel_e;

  typedef struct packed {
    logic                clrLo;
    logic                clrHi;
    logic                maskLo;
    logic                maskHi;
    logic                rstHit;
    logic [CH_IDX_W-1:0] rstCh;
    logic                rdEn;
    rdSel_e              rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  output ctrlStrobes_t      st
);

  localparam logic [ADDR_W-1:0] OFF_STAT_LO = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] OFF_STAT_HI = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] OFF_CLR_LO  = ADDR_W'(12'h014);
  localparam logic [ADDR_W-1:0] OFF_CLR_HI  = ADDR_W'(12'h018);
  localparam logic [ADDR_W-1:0] OFF_MASK_LO = ADDR_W'(12'h01C);
  localparam logic [ADDR_W-1:0] OFF_MASK_HI = ADDR_W'(12'h020);
  localparam logic [ADDR_W-1:0] RST_BASE    = ADDR_W'(12'h040);
  localparam logic [ADDR_W-1:0] RST_END     = ADDR_W'(64 + 4 * NUM_CH);
  localparam bit                HAS_HI      = (NUM_CH > WORD_W);

  logic              inRstRange;
  logic [ADDR_W-1:0] rstOffs;

  assign inRstRange = (busAddr >= RST_BASE) && (busAddr < RST_END) &&
                      (busAddr[1:0] == 2'b00);
  assign rstOffs    = busAddr - RST_BASE;

  always_comb begin
    st        = '0;
    st.rdSel  = RD_ZERO;
    st.rdEn   = busRead;
    st.rstCh  = rstOffs[CH_IDX_W+1:2];
    if (busWrite) begin
      st.clrLo  = (busAddr == OFF_CLR_LO);
      st.clrHi  = HAS_HI && (busAddr == OFF_CLR_HI);
      st.maskLo = (busAddr == OFF_MASK_LO);
      st.maskHi = HAS_HI && (busAddr == OFF_MASK_HI);
      st.rstHit = inRstRange;
    end
    if (busAddr == OFF_STAT_LO)                st.rdSel = RD_STAT_LO;
    else if (HAS_HI && busAddr == OFF_STAT_HI) st.rdSel = RD_STAT_HI;
    else if (busAddr == OFF_MASK_LO)           st.rdSel = RD_MASK_LO;
    else if (HAS_HI && busAddr == OFF_MASK_HI) st.rdSel = RD_MASK_HI;
    else                                       st.rdSel = RD_ZERO;
  end

  // R8: a write decodes to at most one register target
  p_one_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.clrLo, st.clrHi, st.maskLo, st.maskHi, st.rstHit}));

  // R9: a decoded reset slot always names an existing channel
  p_rst_in_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.rstHit |-> (int'(st.rstCh) < NUM_CH));

endmodule

// File: rtl/dmairq_datapath.sv
module dmairq_datapath
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      st,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [NUM_CH-1:0] doneIn,
  output logic [WORD_W-1:0] busRdata,
  output logic [NUM_CH-1:0] chanRst,
  output logic              irqOut
);

  logic [NUM_CH-1:0] statusQ;
  logic [NUM_CH-1:0] maskQ;
  logic [NUM_CH-1:0] clrVec;
  logic [NUM_CH-1:0] rstVec;
  logic [NUM_CH-1:0] maskNext;
  logic [NUM_CH-1:0] chanRstQ;
  logic              irqQ;
  logic [WORD_W-1:0] rdataQ;
  logic [MAX_CH-1:0] statFull;
  logic [MAX_CH-1:0] maskFull;
  logic              rstReq;

  assign rstReq = st.rstHit && busWdata[0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic hitRst;
    assign hitRst    = rstReq && (st.rstCh == CH_IDX_W'(i));
    assign rstVec[i] = hitRst;
    if (i < WORD_W) begin : g_lo
      assign clrVec[i]   = (st.clrLo && busWdata[i]) || hitRst;
      assign maskNext[i] = st.maskLo ? busWdata[i] : maskQ[i];
    end else begin : g_hi
      assign clrVec[i]   = (st.clrHi && busWdata[i-WORD_W]) || hitRst;
      assign maskNext[i] = st.maskHi ? busWdata[i-WORD_W] : maskQ[i];
    end
  end

  for (genvar i = 0; i < MAX_CH; i++) begin : g_pad
    if (i < NUM_CH) begin : g_real
      assign statFull[i] = statusQ[i];
      assign maskFull[i] = maskQ[i];
    end else begin : g_none
      assign statFull[i] = 1'b0;
      assign maskFull[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ  <= '0;
      maskQ    <= '0;
      chanRstQ <= '0;
      irqQ     <= 1'b0;
    end else begin
      statusQ  <= (statusQ & ~clrVec) | doneIn;
      maskQ    <= maskNext;
      chanRstQ <= rstVec;
      irqQ     <= |(statusQ & maskQ);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (st.rdEn) begin
      unique case (st.rdSel)
        RD_STAT_LO: rdataQ <= statFull[WORD_W-1:0];
        RD_STAT_HI: rdataQ <= statFull[MAX_CH-1:WORD_W];
        RD_MASK_LO: rdataQ <= maskFull[WORD_W-1:0];
        RD_MASK_HI: rdataQ <= maskFull[MAX_CH-1:WORD_W];
        default:    rdataQ <= '0;
      endcase
    end
  end

  assign busRdata = rdataQ;
  assign chanRst  = chanRstQ;
  assign irqOut   = irqQ;

  // R2 and R5: every done pulse leaves its pending bit set, even against a clear
  p_done_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(doneIn) & ~statusQ) == '0));

  // R3: a pending bit only drops when a clear or reset named it
  p_status_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(statusQ) & ~$past(clrVec) & ~statusQ) == '0));

  // R7: the interrupt never rises without a pending bit one cycle earlier
  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(statusQ != '0));

  // R9: at most one channel is reset at a time
  p_rst_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanRst));

  // R9: an accepted reset write produces exactly one pulse next cycle
  p_rst_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> $onehot(chanRst));

  // R11: read data holds while no read is requested
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !st.rdEn |=> $stable(busRdata));

endmodule

// File: rtl/dmairq_agg.sv
module dmairq_agg
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [31:0]       busWdata,
  input  logic              busRead,
  output logic [31:0]       busRdata,
  input  logic [NUM_CH-1:0] doneIn,
  output logic [NUM_CH-1:0] chanRst,
  output logic              irqOut
);

  ctrlStrobes_t strobes;

  dmairq_ctrl #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .busRead  (busRead),
    .st       (strobes)
  );

  dmairq_datapath #(
    .NUM_CH (NUM_CH)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .st       (strobes),
    .busWdata (busWdata),
    .doneIn   (doneIn),
    .busRdata (busRdata),
    .chanRst  (chanRst),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/dmairq_agg_tb.sv
module dmairq_agg_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRead = 1'b0;
  logic [31:0] busRdata;
  logic [63:0] doneIn = '0;
  logic [63:0] chanRst;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state
  bit [63:0] mStat, mMask, mRst;
  bit        mIrq;
  bit [31:0] mRd;

  always #4 clk = ~clk;

  dmairq_agg dut_i (
    .clk (clk), .rstN (rstN), .busAddr (busAddr), .busWrite (busWrite),
    .busWdata (busWdata), .busRead (busRead), .busRdata (busRdata),
    .doneIn (doneIn), .chanRst (chanRst), .irqOut (irqOut)
  );

  always @(posedge clk) begin
    bit [63:0] clr, nRst;
    bit        nIrq;
    if (!rstN) begin
      mStat = '0; mMask = '0; mRst = '0; mIrq = 1'b0; mRd = '0;
    end else begin
      nIrq = |(mStat & mMask);
      nRst = '0;
      clr  = '0;
      if (busRead) begin
        case (busAddr)
          12'h00C: mRd = mStat[31:0];
          12'h010: mRd = mStat[63:32];
          12'h01C: mRd = mMask[31:0];
          12'h020: mRd = mMask[63:32];
          default: mRd = '0;
        endcase
      end
      if (busWrite) begin
        if (busAddr == 12'h014) clr[31:0] = busWdata;
        if (busAddr == 12'h018) clr[63:32] = busWdata;
        if (busAddr == 12'h01C) mMask[31:0] = busWdata;
        if (busAddr == 12'h020) mMask[63:32] = busWdata;
        if (busAddr >= 12'h040 && busAddr < 12'h140 && busAddr[1:0] == 2'b00 &&
            busWdata[0]) begin
          nRst[(busAddr - 12'h040) >> 2] = 1'b1;
          clr[(busAddr - 12'h040) >> 2]  = 1'b1;
        end
      end
      mStat = (mStat & ~clr) | doneIn;
      mIrq  = nIrq;
      mRst  = nRst;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks += 3;
      if (irqOut !== mIrq) begin
        errors++;
        $display("FAIL R7 model irqOut actual %0b expected %0b", irqOut, mIrq);
      end
      if (chanRst !== mRst) begin
        errors++;
        $display("FAIL R9 model chanRst actual %h expected %h", chanRst, mRst);
      end
      if (busRdata !== mRd) begin
        errors++;
        $display("FAIL R11 model busRdata actual %h expected %h", busRdata, mRd);
      end
    end
  end

  task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    busAddr = a; busRead = 1'b1;
    @(negedge clk);
    busRead = 1'b0;
  endtask

  task automatic pulse(input int ch);
    doneIn[ch] = 1'b1;
    @(negedge clk);
    doneIn = '0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();
    // R1 reset state
    chk(irqOut, 0, "R1 irq");
    chk(chanRst, 0, "R1 chanRst");
    chk(busRdata, 0, "R1 rdata");
    rd(12'h00C); chk(busRdata, 0, "R1 status lo");
    rd(12'h01C); chk(busRdata, 0, "R1 mask lo");
    // R2 mapping of low and high channels
    pulse(3); pulse(40);
    rd(12'h00C); chk(busRdata, 64'h8, "R2 status lo ch3");
    rd(12'h010); chk(busRdata, 64'h100, "R2 status hi ch40");
    chk(irqOut, 0, "R6 masked no irq");
    // R3 status words ignore writes
    wr(12'h00C, 32'hFFFF_FFFF); wr(12'h010, 32'h0);
    rd(12'h00C); chk(busRdata, 64'h8, "R3 status lo kept");
    rd(12'h010); chk(busRdata, 64'h100, "R3 status hi kept");
    // R6 / R7 enable and registered interrupt
    wr(12'h01C, 32'h8);
    chk(irqOut, 0, "R7 irq one cycle later");
    idle();
    chk(irqOut, 1, "R7 irq asserted");
    rd(12'h01C); chk(busRdata, 64'h8, "R6 mask readback");
    // R4 write-one-to-clear
    wr(12'h014, 32'h4);
    rd(12'h00C); chk(busRdata, 64'h8, "R4 zero bits no effect");
    wr(12'h014, 32'h8);
    rd(12'h00C); chk(busRdata, 64'h0, "R4 clear lo");
    chk(irqOut, 0, "R7 irq drops");
    wr(12'h018, 32'h100);
    rd(12'h010); chk(busRdata, 64'h0, "R4 clear hi");
    // R5 set wins over clear
    doneIn[5] = 1'b1; wr(12'h014, 32'h20); doneIn = '0;
    rd(12'h00C); chk(busRdata, 64'h20, "R5 set wins");
    // R8 zero reads
    rd(12'h014); chk(busRdata, 0, "R8 clr lo reads 0");
    rd(12'h018); chk(busRdata, 0, "R8 clr hi reads 0");
    rd(12'h044); chk(busRdata, 0, "R8 rst slot reads 0");
    rd(12'h000); chk(busRdata, 0, "R8 unmapped 0x00");
    rd(12'h140); chk(busRdata, 0, "R8 unmapped 0x140");
    // R9 / R10 channel reset
    wr(12'h054, 32'h1);
    chk(chanRst, 64'h20, "R9 pulse ch5");
    idle();
    chk(chanRst, 0, "R9 single cycle");
    rd(12'h00C); chk(busRdata, 0, "R10 reset clears status");
    wr(12'h054, 32'h0);
    chk(chanRst, 0, "R9 bit0 clear no pulse");
    doneIn[7] = 1'b1; wr(12'h05C, 32'h1); doneIn = '0;
    chk(chanRst, 64'h80, "R9 pulse ch7");
    rd(12'h00C); chk(busRdata, 64'h80, "R10 done beats reset");
    // high channel 63
    pulse(63);
    wr(12'h020, 32'h8000_0000);
    idle();
    chk(irqOut, 1, "R7 irq from ch63");
    rd(12'h020); chk(busRdata, 64'h8000_0000, "R6 mask hi readback");
    wr(12'h13C, 32'h1);
    chk(chanRst, 64'h8000_0000_0000_0000, "R9 pulse ch63");
    rd(12'h010); chk(busRdata, 0, "R10 ch63 cleared");
    idle();
    chk(irqOut, 0, "R7 irq drops after reset");
    // R11 read returns pre-edge value and holds
    doneIn[9] = 1'b1; rd(12'h00C); doneIn = '0;
    chk(busRdata, 64'h80, "R11 pre-edge value");
    idle(); idle();
    chk(busRdata, 64'h80, "R11 holds");
    rd(12'h00C); chk(busRdata, 64'h280, "R11 updated");
    idle();
    summary();
  end

endmodule